// File: doc/BRIEF.md
# Averaging Position Record Buffer

This block takes pairs of signed 16-bit samples, one pair per machine revolution, and turns them into a decimated history. In the normal mode it adds up a fixed power-of-two number of qualified pairs. It divides each sum by an arithmetic shift and stores the two means as one 64-bit record in a circular region of an internal memory. The oldest record is overwritten once the region has filled. Each record also carries a running record number, so a reader can tell old entries from new ones.

A mode input sends each qualified pair unaveraged into a second circular region, tagged with its own running turn number. A host reads either region through a registered read port at any time. The host uses the two exposed write pointers and the two sticky wrap flags to find the newest entry and to tell whether a region has ever been filled.

Top module: `pos_record_buf`

## Requirements
- R1: While reset is asserted and after it is released, both write pointers are 0, both wrap flags are low, rd_data is 0, and the record and turn numbers start from 0.
- R2: A cycle with smp_valid low writes nothing, does not move a pointer and adds nothing to the running sums, whatever smp_a and smp_b hold.
- R3: With raw_mode low, the 2^LOG2_N-th qualified pair completes a record, which is written in that same clock edge at averaged slot avg_wptr. The record holds bits [15:0] = floor(sum of smp_a / 2^LOG2_N), bits [31:16] = the same for smp_b (two's complement, rounding toward minus infinity) and bits [63:32] = the record number.
- R4: The sums restart in the same edge that a record is written, so the next qualified pair is the first sample of the next record and no pair is lost between records.
- R5: With raw_mode high, every qualified pair is written at address DEPTH + raw_wptr as bits [15:0] = smp_a, bits [31:16] = smp_b and bits [63:32] = the turn number. No averaged record is produced in that cycle.
- R6: The record number increments by one after each averaged record, and the turn number increments by one after each raw write.
- R7: Each pointer advances by one per write into its own region and wraps from DEPTH-1 to 0. Otherwise it holds its value.
- R8: A region's wrap flag rises on the first wrap of its pointer and stays high until reset.
- R9: rd_data shows the memory word at rd_addr one clock after rd_addr is applied. Addresses 0 to DEPTH-1 are the averaged region and DEPTH to 2*DEPTH-1 are the raw region.
- R10: Every cycle with raw_mode high discards a partly built average, so averaging after a return to raw_mode low starts from an empty sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_mode | input | 1 | 1 = store raw pairs, 0 = average |
| smp_valid | input | 1 | Qualifies smp_a and smp_b this cycle |
| smp_a | input | 16 | First sampler word, signed |
| smp_b | input | 16 | Second sampler word, signed |
| rd_addr | input | $clog2(2*DEPTH) | Host read address |
| rd_data | output | 64 | Registered read data |
| avg_wptr | output | $clog2(DEPTH) | Next averaged slot to be written |
| raw_wptr | output | $clog2(DEPTH) | Next raw slot to be written |
| avg_wrapped | output | 1 | Averaged region has wrapped at least once |
| raw_wrapped | output | 1 | Raw region has wrapped at least once |

## Verification
The first pairs are directed. Full-scale positive and negative pairs show that the sum does not overflow. A sum of -3 over eight pairs shows floor rounding as opposed to truncation. Unqualified pairs carrying large values are interleaved, and a run of back-to-back pairs separates a correct restart of the sum from a lost or double-counted pair at the record boundary. A partial average interrupted by a raw burst shows whether the sum is discarded. A long random run then mixes gaps, mode bursts and both wraps, and every slot is compared with a model built from the requirements.

// File: rtl/pos_rec_pkg.sv
package pos_rec_pkg;
  localparam int SMP_W = 16;
  localparam int SEQ_W = 32;
  localparam int REC_W = SEQ_W + 2 * SMP_W;

  typedef logic [REC_W-1:0] rec_t;

  // record layout: [15:0] first word, [31:16] second word, [63:32] number
  function automatic rec_t pack_rec(logic [SEQ_W-1:0] num,
                                    logic [SMP_W-1:0] w_b,
                                    logic [SMP_W-1:0] w_a);
    return {num, w_b, w_a};
  endfunction

  // ring step: p+1, back to 0 after the last slot
  function automatic int unsigned ring_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/pair_accum.sv
module pair_accum #(
  parameter int LOG2_N = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        flush,
  input  logic [15:0] in_a,
  input  logic [15:0] in_b,
  output logic        commit,
  output logic [15:0] mean_a,
  output logic [15:0] mean_b
);
  localparam int AW = 16 + LOG2_N;

  logic [AW-1:0]     acc_a, acc_b;
  logic [AW-1:0]     tot_a, tot_b;
  logic [LOG2_N-1:0] cnt;
  logic              last_pair;

  // arithmetic shift right by LOG2_N, kept to 16 bits
  function automatic logic [15:0] mean_of(logic [AW-1:0] s);
    return s[AW-1:LOG2_N];
  endfunction

  function automatic logic [AW-1:0] sext(logic [15:0] v);
    return {{LOG2_N{v[15]}}, v};
  endfunction

  assign tot_a     = acc_a + sext(in_a);
  assign tot_b     = acc_b + sext(in_b);
  assign last_pair = (cnt == {LOG2_N{1'b1}});
  assign commit    = take && !flush && last_pair;
  assign mean_a    = mean_of(tot_a);
  assign mean_b    = mean_of(tot_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_b <= '0;
      cnt   <= '0;
    end else if (flush || commit) begin
      acc_a <= '0;
      acc_b <= '0;
      cnt   <= '0;
    end else if (take) begin
      acc_a <= tot_a;
      acc_b <= tot_b;
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr
  import pos_rec_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PW-1:0]    ptr,
  output logic             wrapped,
  output logic [SEQ_W-1:0] num
);
  logic [PW-1:0] ptr_nx;
  logic          at_last;

  assign at_last = (ptr == PW'(DEPTH - 1));
  assign ptr_nx  = PW'(ring_step(int'(ptr), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      wrapped <= 1'b0;
      num     <= '0;
    end else if (adv) begin
      ptr <= ptr_nx;
      num <= num + 1'b1;
      if (at_last) wrapped <= 1'b1;
    end
  end
endmodule

// File: rtl/rec_mem.sv
module rec_mem
  import pos_rec_pkg::*;
#(
  parameter int ENTRIES = 512,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rec_t          wdata,
  input  logic [AW-1:0] raddr,
  output rec_t          rdata
);
  rec_t store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= store[raddr];
  end
endmodule

// File: rtl/pos_record_buf.sv
module pos_record_buf
  import pos_rec_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LOG2_N = 10,
  localparam int PW  = $clog2(DEPTH),
  localparam int AAW = $clog2(2 * DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw_mode,
  input  logic           smp_valid,
  input  logic [15:0]    smp_a,
  input  logic [15:0]    smp_b,
  input  logic [AAW-1:0] rd_addr,
  output logic [63:0]    rd_data,
  output logic [PW-1:0]  avg_wptr,
  output logic [PW-1:0]  raw_wptr,
  output logic           avg_wrapped,
  output logic           raw_wrapped
);
  // named events, also observed by the checker
  logic avg_take_evt;
  logic commit_evt;
  logic raw_wr_evt;

  logic [15:0]      mean_a, mean_b;
  logic [SEQ_W-1:0] avg_num, raw_num;
  logic             mem_we;
  logic [AAW-1:0]   mem_waddr;
  rec_t             mem_wdata;
  rec_t             mem_rdata;

  assign avg_take_evt = smp_valid && !raw_mode;
  assign raw_wr_evt   = smp_valid && raw_mode;

  pair_accum #(.LOG2_N(LOG2_N)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (avg_take_evt),
    .flush  (raw_mode),
    .in_a   (smp_a),
    .in_b   (smp_b),
    .commit (commit_evt),
    .mean_a (mean_a),
    .mean_b (mean_b)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_avg_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (commit_evt),
    .ptr     (avg_wptr),
    .wrapped (avg_wrapped),
    .num     (avg_num)
  );

  ring_ptr #(.DEPTH(DEPTH)) u_raw_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (raw_wr_evt),
    .ptr     (raw_wptr),
    .wrapped (raw_wrapped),
    .num     (raw_num)
  );

  assign mem_we    = commit_evt || raw_wr_evt;
  assign mem_waddr = raw_wr_evt ? (AAW'(DEPTH) + AAW'(raw_wptr)) : AAW'(avg_wptr);
  assign mem_wdata = raw_wr_evt ? pack_rec(raw_num, smp_b, smp_a)
                                : pack_rec(avg_num, mean_b, mean_a);

  rec_mem #(.ENTRIES(2 * DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (mem_rdata)
  );

  assign rd_data = mem_rdata;
endmodule

// File: rtl/pos_record_buf_chk.sv
module pos_record_buf_chk #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          raw_mode,
  input logic          commit_evt,
  input logic          raw_wr_evt,
  input logic [PW-1:0] avg_wptr,
  input logic [PW-1:0] raw_wptr,
  input logic          avg_wrapped,
  input logic          raw_wrapped
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> (!commit_evt && !raw_wr_evt));

  a_r5_raw_no_avg: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && raw_mode) |-> (raw_wr_evt && !commit_evt));

  a_r7_avg_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> avg_wptr == (($past(avg_wptr) == LAST) ? '0 : $past(avg_wptr) + 1'b1));

  a_r7_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(avg_wptr));

  a_r7_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_wr_evt |=> $stable(raw_wptr));

  a_r8_avg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    avg_wrapped |=> avg_wrapped);

  a_r8_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    raw_wrapped |=> raw_wrapped);

  a_r8_avg_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avg_wrapped) |-> ($past(avg_wptr) == LAST && avg_wptr == '0));
endmodule

bind pos_record_buf pos_record_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .raw_mode    (raw_mode),
  .commit_evt  (commit_evt),
  .raw_wr_evt  (raw_wr_evt),
  .avg_wptr    (avg_wptr),
  .raw_wptr    (raw_wptr),
  .avg_wrapped (avg_wrapped),
  .raw_wrapped (raw_wrapped)
);

// File: tb/tb_pos_record_buf.sv
module tb_pos_record_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int LOG2_N = 3;
  localparam int NPAIR  = 1 << LOG2_N;
  localparam int PW  = $clog2(DEPTH);
  localparam int AAW = $clog2(2 * DEPTH);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           raw_mode, smp_valid;
  logic [15:0]    smp_a, smp_b;
  logic [AAW-1:0] rd_addr;
  logic [63:0]    rd_data;
  logic [PW-1:0]  avg_wptr, raw_wptr;
  logic           avg_wrapped, raw_wrapped;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pos_record_buf #(.DEPTH(DEPTH), .LOG2_N(LOG2_N)) dut (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .smp_valid(smp_valid),
    .smp_a(smp_a), .smp_b(smp_b), .rd_addr(rd_addr), .rd_data(rd_data),
    .avg_wptr(avg_wptr), .raw_wptr(raw_wptr),
    .avg_wrapped(avg_wrapped), .raw_wrapped(raw_wrapped)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // requirement model
  logic [63:0] m_mem [2*DEPTH];
  bit          m_ok  [2*DEPTH];
  longint      m_sa, m_sb;
  int          m_cnt, m_wp, m_rp;
  int unsigned m_seq, m_turn;
  bit          m_awrap, m_rwrap;

  function automatic logic [15:0] floor_mean(longint s);
    longint q;
    q = s >>> LOG2_N;
    return q[15:0];
  endfunction

  function automatic longint sx(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit v, bit r, logic [15:0] a, logic [15:0] b);
    if (r) begin
      m_sa = 0; m_sb = 0; m_cnt = 0;
      if (v) begin
        m_mem[DEPTH + m_rp] = {m_turn, b, a};
        m_ok[DEPTH + m_rp]  = 1;
        m_turn++;
        if (m_rp == DEPTH - 1) begin m_rp = 0; m_rwrap = 1; end
        else m_rp++;
      end
    end else if (v) begin
      m_sa += sx(a); m_sb += sx(b); m_cnt++;
      if (m_cnt == NPAIR) begin
        m_mem[m_wp] = {m_seq, floor_mean(m_sb), floor_mean(m_sa)};
        m_ok[m_wp]  = 1;
        m_seq++;
        if (m_wp == DEPTH - 1) begin m_wp = 0; m_awrap = 1; end
        else m_wp++;
        m_sa = 0; m_sb = 0; m_cnt = 0;
      end
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send(bit v, bit r, logic [15:0] a, logic [15:0] b);
    smp_valid = v; raw_mode = r; smp_a = a; smp_b = b;
    @(posedge clk);
    model_step(v, r, a, b);
    @(negedge clk);
    chk(avg_wptr == PW'(m_wp), "R7 avg_wptr", 64'(avg_wptr), 64'(m_wp));
    chk(raw_wptr == PW'(m_rp), "R7 raw_wptr", 64'(raw_wptr), 64'(m_rp));
    chk(avg_wrapped == m_awrap && raw_wrapped == m_rwrap, "R8 wrap flags",
        {avg_wrapped, raw_wrapped}, {m_awrap, m_rwrap});
  endtask

  task automatic rd_check(int addr, string tag);
    smp_valid = 0;
    rd_addr = AAW'(addr);
    @(posedge clk);
    @(negedge clk);
    if (m_ok[addr]) chk(rd_data == m_mem[addr], tag, rd_data, m_mem[addr]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit rmode;
    seed = $urandom(32'd2718);
    for (int i = 0; i < 2 * DEPTH; i++) m_ok[i] = 0;
    m_sa = 0; m_sb = 0; m_cnt = 0; m_wp = 0; m_rp = 0;
    m_seq = 0; m_turn = 0; m_awrap = 0; m_rwrap = 0;
    rst_n = 0; raw_mode = 0; smp_valid = 0; smp_a = '0; smp_b = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_data == 64'd0, "R1 rd_data", rd_data, 64'd0);
    chk(avg_wptr == '0 && raw_wptr == '0, "R1 pointers", {avg_wptr, raw_wptr}, 64'd0);
    chk(!avg_wrapped && !raw_wrapped, "R1 wrap flags", {avg_wrapped, raw_wrapped}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R3: full-scale sums, no overflow
    for (int i = 0; i < NPAIR; i++) send(1, 0, 16'h7FFF, 16'h8000);
    rd_check(0, "R3 full-scale record");

    // R2: floor rounding with unqualified pairs carrying large values
    for (int i = 0; i < NPAIR; i++) begin
      send(0, 0, 16'h7FFF, 16'h7FFF);
      send(1, 0, (i == 0) ? 16'hFFFD : 16'h0000, 16'h0001);
    end
    rd_check(1, "R2 ignored pairs / R3 floor");

    // R4: back-to-back pairs across a record boundary, first wrap
    for (int i = 0; i < 2 * NPAIR; i++) send(1, 0, 16'(i), 16'(100 - i));
    rd_check(2, "R4 boundary first record");
    rd_check(3, "R4 boundary second record");

    // R10: partial average discarded by a raw burst; R5 raw writes and wrap
    for (int i = 0; i < 3; i++) send(1, 0, 16'h4000, 16'h4000);
    for (int i = 0; i < DEPTH + 2; i++) send(1, 1, 16'(16'h1000 + i), 16'(16'h2000 + i));
    for (int i = 0; i < NPAIR; i++) send(1, 0, 16'h0010, 16'hFFF0);
    rd_check(0, "R10 fresh average after raw burst");
    for (int i = DEPTH; i < 2 * DEPTH; i++) rd_check(i, "R5 raw slot");

    // random phase: gaps, mode bursts, both wraps
    @(negedge clk);
    rmode = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) rmode = !rmode;
      send($urandom_range(3) != 0, rmode, 16'($urandom), 16'($urandom));
    end
    for (int i = 0; i < 2 * DEPTH; i++) rd_check(i, "R6 R9 random slot");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule